// File: doc/BRIEF.md
# Compare-Match Timer Channel

This block is one 16-bit timer channel with a single-cycle register port. It counts on an externally selected count enable, compares the count against two programmable values, shapes a waveform from those matches and raises a level interrupt from latched event flags. Software picks how the counter runs. It can count freely and wrap. It can restart from zero on an RC match. With a stop option, an RC match also halts the channel, which gives a one-shot delay.

A command write starts, stops or restarts the channel. The waveform output rises on an RA match and falls on an RC match. This makes square waves of programmable duty, for example 50% with RA at 0 and RC at half the range in free-running mode. Event flags stay latched until the status register is read. An interrupt mask, set and cleared through separate write addresses, decides which flags drive the interrupt.

Top module: `tc_channel`

## Requirements
- R1: After reset the counter is 0, the channel is stopped, wave_o and irq_o are 0, the interrupt mask is 0 and all flags are clear.
- R2: The counter advances by one only on cycles where the channel is running and cnt_en_i is high. On all other cycles it holds, unless a trigger command is written.
- R3: With mode bit 0 clear (free-running), the counter wraps from 0xFFFF to 0 and sets flag bit 0. An RC match sets its flag but does not reset the counter.
- R4: With mode bit 0 set (reload), a counting cycle where the count equals RC returns the counter to 0 and sets flag bit 2.
- R5: With mode bit 1 set (stop on RC), a counting cycle where the count equals RC also stops the channel.
- R6: A write to address 3 is a command. Bit 0 starts the channel, bit 1 stops it, and bit 2 resets the counter to 0. Bits 0 and 2 together start from zero. Bit 1 overrides bit 0.
- R7: wave_o goes high after a counting cycle where the count equals RA. It goes low after one where the count equals RC. If both match in the same cycle, low wins.
- R8: Reading address 6 returns the flags and clears them. The flags are bit 0 wrap, bit 1 RA match and bit 2 RC match. Bit 4 shows whether the channel is running and is not cleared. An event in the same cycle as the read stays set.
- R9: A write to address 4 sets mask bits where the data is 1, and a write to address 5 clears them. Address 4 reads the mask. irq_o is high while any flag is set together with its mask bit.
- R10: Addresses 0, 1, 2 and 7 read the mode (2 bits), RA, RC and the current count. Writes to addresses 0 to 2 store the mode, RA and RC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cnt_en_i | input | 1 | Selected count enable; one tick per high cycle |
| reg_we_i | input | 1 | Register write strobe |
| reg_re_i | input | 1 | Register read strobe (clears flags on address 6) |
| reg_addr_i | input | 3 | Register address |
| reg_wdata_i | input | 16 | Write data |
| reg_rdata_o | output | 16 | Read data, combinational from address |
| wave_o | output | 1 | Compare-shaped waveform |
| irq_o | output | 1 | Level interrupt |

## Verification
The counter is run in each of its three modes. Free-running with RA at 0 and RC at 0x8000 tells a wrap apart from a reload and checks the 50% duty edges. A short reload period checks that the match fires at the RC value itself and not one tick later. The one-shot run ticks well past RC, so the stop is seen as a frozen zero count. Register accesses from a table cover the mask set and clear semantics. Directed sequences then cover disable-over-enable priority, RA equal to RC, gated ticks, and interrupts that are masked and then unmasked.

// File: rtl/tc_pkg.sv
package tc_pkg;
  localparam int unsigned ADDR_W  = 3;
  localparam int unsigned FLAG_W  = 3;
  localparam int unsigned RUN_BIT = 4;

  localparam logic [ADDR_W-1:0] A_MODE = 3'd0;
  localparam logic [ADDR_W-1:0] A_RA   = 3'd1;
  localparam logic [ADDR_W-1:0] A_RC   = 3'd2;
  localparam logic [ADDR_W-1:0] A_CMD  = 3'd3;
  localparam logic [ADDR_W-1:0] A_IEN  = 3'd4;
  localparam logic [ADDR_W-1:0] A_IDIS = 3'd5;
  localparam logic [ADDR_W-1:0] A_STAT = 3'd6;
  localparam logic [ADDR_W-1:0] A_CV   = 3'd7;

  localparam int unsigned F_WRAP = 0;
  localparam int unsigned F_RA   = 1;
  localparam int unsigned F_RC   = 2;

  typedef struct packed {
    logic start;
    logic stop;
    logic trig;
  } cmd_t;

  typedef struct packed {
    logic stop_on_rc;
    logic reload;
  } mode_t;
endpackage

// File: rtl/tc_regs.sv
module tc_regs
  import tc_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [CNT_W-1:0]  wdata_i,
  output mode_t             mode_o,
  output logic [CNT_W-1:0]  ra_o,
  output logic [CNT_W-1:0]  rc_o,
  output logic [FLAG_W-1:0] mask_o,
  output cmd_t              cmd_o
);
  mode_t             mode_q;
  logic [CNT_W-1:0]  ra_q, rc_q;
  logic [FLAG_W-1:0] mask_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= '0;
      ra_q   <= '0;
      rc_q   <= '0;
      mask_q <= '0;
    end else if (we_i) begin
      unique case (addr_i)
        A_MODE:  mode_q <= mode_t'(wdata_i[1:0]);
        A_RA:    ra_q   <= wdata_i;
        A_RC:    rc_q   <= wdata_i;
        A_IEN:   mask_q <= mask_q | wdata_i[FLAG_W-1:0];
        A_IDIS:  mask_q <= mask_q & ~wdata_i[FLAG_W-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    cmd_o = '0;
    if (we_i && addr_i == A_CMD) begin
      cmd_o.start = wdata_i[0];
      cmd_o.stop  = wdata_i[1];
      cmd_o.trig  = wdata_i[2];
    end
  end

  assign mode_o = mode_q;
  assign ra_o   = ra_q;
  assign rc_o   = rc_q;
  assign mask_o = mask_q;

  AST_IDIS_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == A_IDIS) |=> ((mask_q & $past(wdata_i[FLAG_W-1:0])) == '0)); // R9
endmodule

// File: rtl/tc_counter.sv
module tc_counter
  import tc_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cnt_en_i,
  input  mode_t            mode_i,
  input  logic [CNT_W-1:0] ra_i,
  input  logic [CNT_W-1:0] rc_i,
  input  cmd_t             cmd_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             running_o,
  output logic             ra_hit_o,
  output logic             rc_hit_o,
  output logic             wrap_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             run_q, run_d;
  logic             tick;

  assign tick     = run_q & cnt_en_i;
  assign ra_hit_o = tick & (cnt_q == ra_i);
  assign rc_hit_o = tick & (cnt_q == rc_i);
  // a reload at the top value is a reload, not a wrap
  assign wrap_o   = tick & (cnt_q == CNT_MAX) & ~(mode_i.reload & rc_hit_o);

  always_comb begin
    cnt_d = cnt_q;
    if (cmd_i.trig)                       cnt_d = '0;
    else if (tick) begin
      if (mode_i.reload && rc_hit_o)      cnt_d = '0;
      else                                cnt_d = cnt_q + 1'b1;
    end
  end

  always_comb begin
    run_d = run_q;
    if (cmd_i.stop)                          run_d = 1'b0;
    else if (cmd_i.start)                    run_d = 1'b1;
    else if (rc_hit_o && mode_i.stop_on_rc)  run_d = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      run_q <= run_d;
    end
  end

  assign cnt_o     = cnt_q;
  assign running_o = run_q;

  AST_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!(run_q && cnt_en_i) && !cmd_i.trig) |=> $stable(cnt_q)); // R2
  AST_DIS_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_i.stop |=> !run_q); // R6
  AST_TRIG_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_i.trig |=> (cnt_q == '0)); // R6
  AST_RELOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && cnt_en_i && mode_i.reload && cnt_q == rc_i) |=> (cnt_q == '0)); // R4
  AST_ONESHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && cnt_en_i && mode_i.stop_on_rc && cnt_q == rc_i && !cmd_i.start) |=> !run_q); // R5
endmodule

// File: rtl/tc_wave.sv
module tc_wave (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ra_hit_i,
  input  logic rc_hit_i,
  output logic wave_o
);
  logic wave_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       wave_q <= 1'b0;
    else if (rc_hit_i) wave_q <= 1'b0;
    else if (ra_hit_i) wave_q <= 1'b1;
  end

  assign wave_o = wave_q;

  AST_RC_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rc_hit_i |=> !wave_o); // R7
  AST_RA_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ra_hit_i && !rc_hit_i) |=> wave_o); // R7
endmodule

// File: rtl/tc_irq.sv
module tc_irq
  import tc_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [FLAG_W-1:0] set_i,
  input  logic              clr_i,
  input  logic [FLAG_W-1:0] mask_i,
  output logic [FLAG_W-1:0] flags_o,
  output logic              irq_o
);
  logic [FLAG_W-1:0] flags_q;

  // a same-cycle event survives the read-clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flags_q <= '0;
    else         flags_q <= (clr_i ? '0 : flags_q) | set_i;
  end

  assign flags_o = flags_q;
  assign irq_o   = |(flags_q & mask_i);

  AST_FLAG_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|set_i) |=> ((flags_q & $past(set_i)) == $past(set_i))); // R8
  AST_CLR_ON_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && set_i == '0) |=> (flags_q == '0)); // R8
  AST_IRQ_MASKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask_i == '0) |-> !irq_o); // R9
endmodule

// File: rtl/tc_channel.sv
module tc_channel
  import tc_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cnt_en_i,
  input  logic              reg_we_i,
  input  logic              reg_re_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [CNT_W-1:0]  reg_wdata_i,
  output logic [CNT_W-1:0]  reg_rdata_o,
  output logic              wave_o,
  output logic              irq_o
);
  mode_t             mode;
  cmd_t              cmd;
  logic [CNT_W-1:0]  ra, rc, cnt;
  logic [FLAG_W-1:0] mask, flags, events;
  logic              running, ra_hit, rc_hit, wrap;

  tc_regs #(.CNT_W(CNT_W)) regs_i (
    .clk_i, .rst_ni,
    .we_i(reg_we_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i),
    .mode_o(mode), .ra_o(ra), .rc_o(rc), .mask_o(mask), .cmd_o(cmd)
  );

  tc_counter #(.CNT_W(CNT_W)) cnt_i (
    .clk_i, .rst_ni, .cnt_en_i,
    .mode_i(mode), .ra_i(ra), .rc_i(rc), .cmd_i(cmd),
    .cnt_o(cnt), .running_o(running),
    .ra_hit_o(ra_hit), .rc_hit_o(rc_hit), .wrap_o(wrap)
  );

  tc_wave wave_i (
    .clk_i, .rst_ni, .ra_hit_i(ra_hit), .rc_hit_i(rc_hit), .wave_o
  );

  always_comb begin
    events         = '0;
    events[F_WRAP] = wrap;
    events[F_RA]   = ra_hit;
    events[F_RC]   = rc_hit;
  end

  tc_irq irq_i (
    .clk_i, .rst_ni,
    .set_i(events), .clr_i(reg_re_i && reg_addr_i == A_STAT),
    .mask_i(mask), .flags_o(flags), .irq_o
  );

  always_comb begin
    reg_rdata_o = '0;
    unique case (reg_addr_i)
      A_MODE: reg_rdata_o[1:0] = mode;
      A_RA:   reg_rdata_o = ra;
      A_RC:   reg_rdata_o = rc;
      A_IEN:  reg_rdata_o[FLAG_W-1:0] = mask;
      A_STAT: begin
        reg_rdata_o[FLAG_W-1:0] = flags;
        reg_rdata_o[RUN_BIT]    = running;
      end
      A_CV:   reg_rdata_o = cnt;
      default: ;
    endcase
  end
endmodule

// File: tb/tc_channel_tb.sv
module tc_channel_tb_top;
  localparam int CLK_P = 10;
  localparam int NV = 10;
  // {we, addr, wdata, expected read}
  localparam logic [35:0] VEC [NV] = '{
    {1'b1, 3'd0, 16'hFFFF, 16'h0000},
    {1'b0, 3'd0, 16'h0000, 16'h0003},
    {1'b1, 3'd1, 16'h1234, 16'h0000},
    {1'b0, 3'd1, 16'h0000, 16'h1234},
    {1'b1, 3'd2, 16'hBEEF, 16'h0000},
    {1'b0, 3'd2, 16'h0000, 16'hBEEF},
    {1'b1, 3'd4, 16'h0005, 16'h0000},
    {1'b0, 3'd4, 16'h0000, 16'h0005},
    {1'b1, 3'd5, 16'h0001, 16'h0000},
    {1'b0, 3'd4, 16'h0000, 16'h0004}
  };

  logic clk = 0, rst_n = 0, cnt_en = 0, we = 0, re = 0;
  logic [2:0]  addr = '0;
  logic [15:0] wdata = '0, rdata;
  logic wave, irq;
  int n_chk = 0, n_fail = 0;
  bit done = 0;
  logic [15:0] v;

  always #(CLK_P/2) clk = ~clk;

  tc_channel dut_i (
    .clk_i(clk), .rst_ni(rst_n), .cnt_en_i(cnt_en),
    .reg_we_i(we), .reg_re_i(re), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .wave_o(wave), .irq_o(irq)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [15:0] d);
    @(negedge clk); we = 1; addr = a; wdata = d;
    @(posedge clk); #1 we = 0;
  endtask

  task automatic rd(logic [2:0] a, output logic [15:0] d);
    @(negedge clk); re = 1; addr = a; #1 d = rdata;
    @(posedge clk); #1 re = 0;
  endtask

  task automatic run(int n);
    @(negedge clk); cnt_en = 1;
    repeat (n) @(posedge clk);
    #1 cnt_en = 0;
  endtask

  initial begin
    #(CLK_P*190000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // R1 reset state
    rd(3'd7, v); chk("R1 count", v, 0);
    rd(3'd6, v); chk("R1 status", v, 0);
    rd(3'd4, v); chk("R1 mask", v, 0);
    chk("R1 wave", wave, 0);
    chk("R1 irq", irq, 0);

    // register table: R10 and R9
    for (int i = 0; i < NV; i++) begin
      if (VEC[i][35]) wr(VEC[i][34:32], VEC[i][31:16]);
      else begin
        rd(VEC[i][34:32], v);
        chk((VEC[i][34:32] == 3'd4) ? "R9 mask" : "R10 readback", v, VEC[i][15:0]);
      end
    end
    wr(3'd5, 16'hFF);
    wr(3'd1, 16'h0000);
    wr(3'd2, 16'h0000);

    // R2 gating and R6 commands
    wr(3'd0, 16'h0);
    wr(3'd3, 16'h5);
    repeat (5) @(posedge clk);
    rd(3'd7, v); chk("R2 no tick without enable", v, 0);
    run(10);
    rd(3'd7, v); chk("R2 ten ticks", v, 10);
    wr(3'd3, 16'h2);
    run(5);
    rd(3'd7, v); chk("R6 disable stops count", v, 10);
    wr(3'd3, 16'h3);
    rd(3'd6, v); chk("R6 disable beats enable", v[4], 0);
    wr(3'd3, 16'h1);
    rd(3'd6, v); chk("R6 enable", v[4], 1);
    wr(3'd3, 16'h4);
    rd(3'd7, v); chk("R6 trigger zeroes", v, 0);

    // R4 reload
    wr(3'd0, 16'h1); wr(3'd1, 16'h0); wr(3'd2, 16'h4);
    wr(3'd3, 16'h5);
    rd(3'd6, v);
    run(5);
    rd(3'd7, v); chk("R4 reload at RC", v, 0);
    rd(3'd6, v); chk("R4 flags RA RC running", v, 16'h16);
    rd(3'd6, v); chk("R8 clear on read", v, 16'h10);
    run(2);
    rd(3'd7, v); chk("R4 counts after reload", v, 2);

    // R5 one-shot
    wr(3'd0, 16'h3); wr(3'd2, 16'h3);
    wr(3'd3, 16'h5);
    rd(3'd6, v);
    run(10);
    rd(3'd7, v); chk("R5 stopped at zero", v, 0);
    rd(3'd6, v); chk("R5 stopped flags", v, 16'h06);

    // R7 RA == RC
    wr(3'd0, 16'h1); wr(3'd1, 16'h1); wr(3'd2, 16'h3);
    wr(3'd3, 16'h5);
    run(2);
    chk("R7 high after RA", wave, 1);
    wr(3'd1, 16'h2); wr(3'd2, 16'h2);
    run(1);
    chk("R7 RC wins on tie", wave, 0);
    rd(3'd7, v); chk("R4 tie reload", v, 0);

    // R9 interrupt masking
    wr(3'd0, 16'h1); wr(3'd1, 16'h8); wr(3'd2, 16'h1);
    wr(3'd3, 16'h5);
    rd(3'd6, v);
    wr(3'd4, 16'h4);
    chk("R9 no irq without flag", irq, 0);
    run(2);
    chk("R9 irq on RC flag", irq, 1);
    wr(3'd5, 16'hFF);
    chk("R9 masked", irq, 0);
    wr(3'd4, 16'h4);
    chk("R9 unmasked", irq, 1);
    rd(3'd6, v);
    chk("R9 irq drops after read", irq, 0);
    wr(3'd5, 16'hFF);

    // R3 free-running, 50% duty, wrap
    wr(3'd0, 16'h0); wr(3'd1, 16'h0); wr(3'd2, 16'h8000);
    wr(3'd3, 16'h5);
    rd(3'd6, v);
    run(32'h8000);
    chk("R7 high first half", wave, 1);
    rd(3'd6, v); chk("R3 RA flag only", v, 16'h12);
    run(1);
    chk("R7 low at RC", wave, 0);
    rd(3'd7, v); chk("R3 no reset on RC", v, 16'h8001);
    run(32'h7FFF);
    rd(3'd7, v); chk("R3 wrapped", v, 0);
    rd(3'd6, v); chk("R3 wrap and RC flags", v, 16'h15);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule